// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with a pipelined read path and a two-bit burst counter. Each word has four 9-bit byte lanes, so it is 36 bits wide. The depth is set by a parameter. Every control, address and data input is captured on the rising clock edge. Read data goes through an output register before it leaves the block. The output enable bypasses every register and acts on the output drive directly.

Two address strobes can start an access: a processor strobe and a controller strobe. After the start, a two-bit counter produces the next three addresses inside the aligned four-word block. A mode input, sampled when the burst starts, picks one of two orders. Linear order adds the count to the start. Interleaved order XORs the count with the start. Writes can cover the whole word or selected byte lanes. Deselecting through the chip enables stops both reads and writes.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the output is not driven (`data_en_o` low), and it stays undriven until a selected read has come through the output register.
- R2: With `adsp_ni` low and `ce1_ni` low at an edge, or with `adsc_ni` low, the block loads `addr_i` and clears the burst count. When `ce1_ni` is high, `adsp_ni` is ignored: the cycle acts as a continuation cycle and the burst address keeps going.
- R3: For a read captured at edge k, the data is driven after edge k+1. Continuation reads at later edges drive one word per cycle (3-1-1-1). A write cycle never drives the output after its stage.
- R4: A cycle that starts at the processor strobe is always a read, even when write enables are low. A write then needs a continuation cycle with the write enables asserted. With `adv_ni` high, that write goes to the same address.
- R5: With `mode_i`=0 (linear), the two low address bits of burst word n are (start + n) mod 4.
- R6: With `mode_i`=1 (interleaved), the two low address bits of burst word n are start XOR n. `mode_i` is sampled only at a load. The bits above bit 1 never change during a burst.
- R7: The burst counter moves forward only in continuation cycles with `adv_ni` low. With `adv_ni` high, the same address is accessed again.
- R8: `gw_ni` low writes all four byte lanes, whatever `bwe_ni` and `bw_ni` are.
- R9: With `gw_ni` high and `bwe_ni` low, byte lane i (data bits 9i+8..9i) is written only when `bw_ni[i]` is 0. With `gw_ni` and `bwe_ni` both high, the cycle is a read.
- R10: `data_en_o` equals (a selected read is held in the output register) AND NOT `oe_ni`. It follows `oe_ni` with no clock edge. `data_o` is high impedance whenever `data_en_o` is low.
- R11: A load with the enables inactive deselects the block. This is `adsc_ni` low with `ce1_ni` high, or any strobe with `ce2_i` low or `ce3_ni` high. The output is then undriven after the second edge. Continuation cycles that follow neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, loaded by a strobe |
| data_i | input | 36 | Write data |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Expansion enable, active high |
| ce3_ni | input | 1 | Expansion enable, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | 4 | Per-lane byte write select, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_o | output | 36 | Read data, high impedance when not driven |
| data_en_o | output | 1 | Output drive indicator |

## Verification
The assertions check on every cycle that the drive is gated by the output enable, that the upper address bits hold while no strobe is accepted, that a processor-strobe cycle never becomes a write, and that a write or a deselect leaves the output undriven. Other properties need the stored contents, so only the bench's scenarios can show them. These are the actual burst orders in both modes, the wrap inside the four-word block, the merge of partial byte writes, the write that follows a processor-strobe read, and the fact that writes after a deselect leave memory untouched.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input burst_order_e ord);
    return (ord == ORDER_INTERLEAVE) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbs_byte_decode.sv
module sbs_byte_decode #(
  parameter int NUM_BYTES = 4
) (
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  output logic                 wr_o,
  output logic [NUM_BYTES-1:0] be_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign be_o[g] = ~gw_ni | (~bwe_ni & ~bw_ni[g]);
  end
  assign wr_o = |be_o;
endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 36,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 adsp_ni,
  input  logic                 adsc_ni,
  input  logic                 adv_ni,
  input  logic                 mode_i,
  input  logic                 wr_i,
  input  logic [NUM_BYTES-1:0] be_i,
  output logic                 op_vld_o,
  output logic                 op_wr_o,
  output logic [NUM_BYTES-1:0] op_be_o,
  output logic [ADDR_W-1:0]    op_addr_o,
  output logic [DATA_W-1:0]    op_din_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d, lsb;
  burst_order_e      ord_q, ord_d;
  logic              act_q, act_d;
  logic              p_ld, c_ld, ld, en_ok, wr_d;

  always_comb begin
    p_ld  = ~adsp_ni & ~ce1_ni;
    c_ld  = ~adsc_ni & ~p_ld;
    ld    = p_ld | c_ld;
    en_ok = ce2_i & ~ce3_ni;
    if (p_ld)      act_d = en_ok;
    else if (c_ld) act_d = ~ce1_ni & en_ok;
    else           act_d = act_q;
    base_d = ld ? addr_i : base_q;
    ord_d  = ld ? burst_order_e'(mode_i) : ord_q;
    cnt_d  = ld ? 2'd0 : cnt_q + {1'b0, act_q & ~adv_ni};
    // processor-strobe cycle is forced to read
    wr_d   = ~p_ld & wr_i;
    lsb    = burst_lsb(base_d[1:0], cnt_d, ord_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      cnt_q     <= '0;
      ord_q     <= ORDER_LINEAR;
      act_q     <= 1'b0;
      op_vld_o  <= 1'b0;
      op_wr_o   <= 1'b0;
      op_be_o   <= '0;
      op_addr_o <= '0;
      op_din_o  <= '0;
    end else begin
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      ord_q     <= ord_d;
      act_q     <= act_d;
      op_vld_o  <= act_d;
      op_wr_o   <= wr_d;
      op_be_o   <= be_i;
      op_addr_o <= {base_d[ADDR_W-1:2], lsb};
      op_din_o  <= data_i;
    end
  end
endmodule

// File: rtl/sbs_mem_pipe.sv
module sbs_mem_pipe #(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        op_vld_i,
  input  logic                        op_wr_i,
  input  logic [NUM_BYTES-1:0]        op_be_i,
  input  logic [ADDR_W-1:0]           op_addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] op_din_i,
  output logic                        rd_o,
  output logic [NUM_BYTES*BYTE_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i) begin
      if (op_vld_i && op_wr_i && op_be_i[g])
        lane_mem[op_addr_i] <= op_din_i[g*BYTE_W +: BYTE_W];
      if (op_vld_i && !op_wr_i)
        lane_q <= lane_mem[op_addr_i];
    end
    assign q_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_o <= 1'b0;
    else         rd_o <= op_vld_i & ~op_wr_i;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] data_i,
  input  logic                        ce1_ni,
  input  logic                        ce2_i,
  input  logic                        ce3_ni,
  input  logic                        adsp_ni,
  input  logic                        adsc_ni,
  input  logic                        adv_ni,
  input  logic                        mode_i,
  input  logic                        gw_ni,
  input  logic                        bwe_ni,
  input  logic [NUM_BYTES-1:0]        bw_ni,
  input  logic                        oe_ni,
  output logic [NUM_BYTES*BYTE_W-1:0] data_o,
  output logic                        data_en_o
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic                 wr_req;
  logic [NUM_BYTES-1:0] be_req;
  logic                 op_vld, op_wr;
  logic [NUM_BYTES-1:0] op_be;
  logic [ADDR_W-1:0]    op_addr;
  logic [DATA_W-1:0]    op_din;
  logic                 rd_q;
  logic [DATA_W-1:0]    q;

  sbs_byte_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
    .gw_ni (gw_ni),
    .bwe_ni(bwe_ni),
    .bw_ni (bw_ni),
    .wr_o  (wr_req),
    .be_o  (be_req)
  );

  sbs_burst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .ce1_ni   (ce1_ni),
    .ce2_i    (ce2_i),
    .ce3_ni   (ce3_ni),
    .adsp_ni  (adsp_ni),
    .adsc_ni  (adsc_ni),
    .adv_ni   (adv_ni),
    .mode_i   (mode_i),
    .wr_i     (wr_req),
    .be_i     (be_req),
    .op_vld_o (op_vld),
    .op_wr_o  (op_wr),
    .op_be_o  (op_be),
    .op_addr_o(op_addr),
    .op_din_o (op_din)
  );

  sbs_mem_pipe #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_vld_i (op_vld),
    .op_wr_i  (op_wr),
    .op_be_i  (op_be),
    .op_addr_i(op_addr),
    .op_din_i (op_din),
    .rd_o     (rd_q),
    .q_o      (q)
  );

  // output enable is not registered
  assign data_en_o = rd_q & ~oe_ni;
  assign data_o    = data_en_o ? q : {DATA_W{1'bz}};
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adsp_ni,
  input logic              adsc_ni,
  input logic              ce1_ni,
  input logic              oe_ni,
  input logic              data_en_o,
  input logic              op_vld_i,
  input logic              op_wr_i,
  input logic [ADDR_W-1:0] op_addr_i
);
  // R10
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> !oe_ni);

  // R2
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsc_ni && (adsp_ni || ce1_ni) && op_vld_i)
      |=> (op_addr_i[ADDR_W-1:2] == $past(op_addr_i[ADDR_W-1:2])));

  // R4
  adsp_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce1_ni) |=> !op_wr_i);

  // R11
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!adsc_ni && ce1_ni) |=> !data_en_o);

  // R3
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_i && op_wr_i) |=> !data_en_o);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .adsp_ni  (adsp_ni),
  .adsc_ni  (adsc_ni),
  .ce1_ni   (ce1_ni),
  .oe_ni    (oe_ni),
  .data_en_o(data_en_o),
  .op_vld_i (op_vld),
  .op_wr_i  (op_wr),
  .op_addr_i(op_addr)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
  localparam int AW = 8, BW = 9, NB = 4, DW = 36;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] data_i;
  logic ce1_ni, ce2_i, ce3_ni, adsp_ni, adsc_ni, adv_ni, mode_i;
  logic gw_ni, bwe_ni, oe_ni;
  logic [NB-1:0] bw_ni;
  wire  [DW-1:0] data_o;
  wire           data_en_o;

  sync_burst_sram #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni), .adsp_ni(adsp_ni),
    .adsc_ni(adsc_ni), .adv_ni(adv_ni), .mode_i(mode_i), .gw_ni(gw_ni),
    .bwe_ni(bwe_ni), .bw_ni(bw_ni), .oe_ni(oe_ni), .data_o(data_o),
    .data_en_o(data_en_o)
  );

  always #2 clk_i = ~clk_i;

  int vec_cnt = 0, err_cnt = 0;
  string tag = "R1";
  bit chk_on = 1'b0;
  logic [DW-1:0] got_q[$];

  // reference model state
  logic [DW-1:0] ref_mem [0:255];
  bit m_vld, m_wr, b_act, b_ilv, exp_rd;
  logic [NB-1:0] m_be;
  logic [AW-1:0] m_addr, b_base;
  logic [DW-1:0] m_din, exp_q;
  int b_cnt;

  function automatic logic [DW-1:0] pat(input logic [7:0] a);
    return {4'hA, a, ~a, a ^ 8'h3C, 8'h5C};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_vld = 0; m_wr = 0; b_act = 0; b_ilv = 0; exp_rd = 0; b_cnt = 0;
    end else begin : step
      bit pl, cl;
      logic [NB-1:0] be;
      int lo;
      if (m_vld && m_wr)
        for (int b = 0; b < NB; b++)
          if (m_be[b]) ref_mem[m_addr][b*BW +: BW] = m_din[b*BW +: BW];
      exp_rd = m_vld && !m_wr;
      if (exp_rd) exp_q = ref_mem[m_addr];
      pl = !adsp_ni && !ce1_ni;
      cl = !adsc_ni && !pl;
      for (int b = 0; b < NB; b++) be[b] = !gw_ni || (!bwe_ni && !bw_ni[b]);
      if (pl || cl) begin
        b_base = addr_i; b_cnt = 0; b_ilv = mode_i;
        b_act = pl ? (ce2_i && !ce3_ni) : (!ce1_ni && ce2_i && !ce3_ni);
      end else if (b_act && !adv_ni) b_cnt = (b_cnt + 1) % 4;
      m_vld = b_act;
      m_wr  = !pl && (be != 0);
      m_be  = be;
      m_din = data_i;
      lo = b_ilv ? (b_base[1:0] ^ b_cnt[1:0]) : ((b_base[1:0] + b_cnt) % 4);
      m_addr = {b_base[7:2], lo[1:0]};
    end
  end

  always @(negedge clk_i) begin
    #1;
    if (chk_on) begin : cmp
      bit e_en;
      e_en = exp_rd && !oe_ni;
      vec_cnt++;
      if (data_en_o !== e_en) begin
        err_cnt++;
        $display("FAIL %s: data_en_o=%0b expected %0b", tag, data_en_o, e_en);
      end else if (e_en && data_o !== exp_q) begin
        err_cnt++;
        $display("FAIL %s: data_o=%h expected %h", tag, data_o, exp_q);
      end
      if (data_en_o === 1'b1) got_q.push_back(data_o);
    end
  end

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic chk_got(input string t, input int n, input int a0, input int a1,
                         input int a2, input int a3);
    int a[4];
    a = '{a0, a1, a2, a3};
    chk({t, " count"}, 36'(got_q.size()), 36'(n));
    for (int k = 0; k < n && k < got_q.size(); k++) chk(t, got_q[k], pat(8'(a[k])));
  endtask

  task automatic idle();
    adsp_ni = 1; adsc_ni = 1; adv_ni = 1; gw_ni = 1; bwe_ni = 1; bw_ni = '1;
    ce1_ni = 0; ce2_i = 1; ce3_ni = 0;
  endtask

  task automatic desel();
    adsc_ni = 0; ce1_ni = 1;
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr_blk(input logic [7:0] a);
    adsc_ni = 0; addr_i = a; mode_i = 0; gw_ni = 0; data_i = pat(a);
    @(negedge clk_i);
    adsc_ni = 1; adv_ni = 0;
    for (int k = 1; k < 4; k++) begin
      data_i = pat(8'(a + k));
      @(negedge clk_i);
    end
    idle();
    desel();
  endtask

  // advp[k]=1 advances on continuation cycle k
  task automatic rd_burst(input logic [7:0] a, input bit ilv, input bit use_p,
                          input logic [2:0] advp);
    got_q.delete();
    addr_i = a; mode_i = ilv;
    if (use_p) adsp_ni = 0; else adsc_ni = 0;
    @(negedge clk_i);
    adsp_ni = 1; adsc_ni = 1;
    for (int k = 0; k < 3; k++) begin
      adv_ni = !advp[k];
      @(negedge clk_i);
    end
    idle();
    desel();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    err_cnt++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] e;
    idle(); oe_ni = 0; mode_i = 0; addr_i = '0; data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_on = 1;
    #1.5 chk("R1 reset drive", 36'(data_en_o), 36'(0));
    @(negedge clk_i);

    tag = "R8";
    for (int blk = 0; blk < 8; blk++) wr_blk(8'(blk * 4));

    tag = "R5"; rd_burst(8'd6, 0, 1, 3'b111);
    chk_got("R5 linear", 4, 6, 7, 4, 5);
    rd_burst(8'd15, 0, 0, 3'b111);
    chk_got("R5 wrap", 4, 15, 12, 13, 14);

    tag = "R6"; rd_burst(8'd9, 1, 1, 3'b111);
    chk_got("R6 interleave", 4, 9, 8, 11, 10);

    tag = "R7"; rd_burst(8'd20, 0, 1, 3'b010);
    chk_got("R7 hold", 4, 20, 20, 21, 21);

    tag = "R2"; got_q.delete();
    adsc_ni = 0; addr_i = 8'd0; mode_i = 0;
    @(negedge clk_i);
    adsc_ni = 1; adsp_ni = 0; ce1_ni = 1; addr_i = 8'd40; adv_ni = 0;
    @(negedge clk_i);
    adsp_ni = 1; ce1_ni = 0; adv_ni = 0;
    @(negedge clk_i);
    idle(); desel(); repeat (2) @(negedge clk_i);
    chk_got("R2 adsp ignored", 3, 0, 1, 2, 0);

    tag = "R9"; got_q.delete();
    adsc_ni = 0; addr_i = 8'd25; bwe_ni = 0; bw_ni = 4'b1010; data_i = '1;
    @(negedge clk_i);
    idle(); desel();
    adsc_ni = 0; addr_i = 8'd25; bw_ni = 4'b0000; data_i = '0;
    @(negedge clk_i);
    idle(); desel(); repeat (2) @(negedge clk_i);
    e = pat(8'd25); e[8:0] = 9'h1FF; e[26:18] = 9'h1FF;
    chk("R9 count", 36'(got_q.size()), 36'(1));
    if (got_q.size() > 0) chk("R9 byte merge", got_q[0], e);

    tag = "R4"; got_q.delete();
    adsp_ni = 0; addr_i = 8'd28; gw_ni = 0; data_i = '0;
    @(negedge clk_i);
    adsp_ni = 1; gw_ni = 0; adv_ni = 1; data_i = 36'h123456789;
    @(negedge clk_i);
    idle(); desel(); repeat (2) @(negedge clk_i);
    chk_got("R4 adsp read", 1, 28, 0, 0, 0);
    rd_burst(8'd28, 0, 1, 3'b000);
    chk("R4 count", 36'(got_q.size()), 36'(4));
    if (got_q.size() > 0) chk("R4 follow-on write", got_q[0], 36'h123456789);

    tag = "R10"; oe_ni = 1;
    rd_burst(8'd3, 0, 1, 3'b111);
    chk("R10 oe high count", 36'(got_q.size()), 36'(0));
    oe_ni = 0;
    adsp_ni = 0; addr_i = 8'd2;
    @(negedge clk_i);
    idle();
    repeat (2) @(negedge clk_i);
    #1.3 oe_ni = 1;
    #0.2 chk("R10 async off", 36'(data_en_o), 36'(0));
    oe_ni = 0;
    #0.2 chk("R10 async on", 36'(data_en_o), 36'(1));
    chk("R10 async data", data_o, pat(8'd2));
    @(negedge clk_i);
    desel(); repeat (2) @(negedge clk_i);

    tag = "R11"; got_q.delete();
    adsp_ni = 0; addr_i = 8'd4;
    @(negedge clk_i);
    adsp_ni = 1; adsc_ni = 0; ce1_ni = 1;
    @(negedge clk_i);
    adsc_ni = 1; ce1_ni = 0; gw_ni = 0; adv_ni = 0; data_i = '0;
    repeat (3) @(negedge clk_i);
    idle(); repeat (2) @(negedge clk_i);
    chk_got("R11 deselect", 1, 4, 0, 0, 0);
    rd_burst(8'd4, 0, 1, 3'b111);
    chk_got("R11 no write", 4, 4, 5, 6, 7);
    got_q.delete();
    adsp_ni = 0; addr_i = 8'd8; ce2_i = 0;
    @(negedge clk_i);
    adsp_ni = 1; ce2_i = 1; adv_ni = 0;
    repeat (3) @(negedge clk_i);
    idle(); repeat (2) @(negedge clk_i);
    chk("R11 ce2 deselect", 36'(got_q.size()), 36'(0));

    chk_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule